// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a synthesizable, cycle-accurate model of a synchronous static RAM built for zero bus turnaround. On every clock edge where the active-low clock enable is low, it samples address, direction, the load/advance select and three chip selects. A load takes a new address and a new direction. An advance steps an internal four-beat burst counter and keeps the direction of the last load. Read data for a beat taken at an edge appears combinationally during the following cycle, with no output register stage. Write data for a beat is presented during the following cycle and is stored at the next enabled edge under per-lane active-low write strobes.

Because writes arrive one cycle late, as reads do, reads and writes can alternate on consecutive cycles with no idle slot. A new load may also directly follow the last beat of a burst. The data output is tri-state in style: `dout_drive` says whether the block drives the bus, and `dout` reads as zero whenever it does not.

Top module: `zbt_ft_sram`

## Requirements
- R1: While reset is low and after reset is released, until a selected read is loaded, `dout_drive` is 0 and `dout` is 0.
- R2: An edge where `en_n` is 1 changes no state. The burst position, the direction and a pending write all wait, so `dout` and `dout_drive` keep their values while `out_en_n` stays the same. The write data of a pending beat is taken at the next edge where `en_n` is 0.
- R3: A load (`burst_adv` = 0 at an enabled edge) selects the device only when `sel0_n` = 0, `sel1_n` = 0 and `sel2` = 1. `rd_wr_n` = 1 means read and 0 means write.
- R4: For a read beat taken at edge n, with `out_en_n` = 0, `dout` carries the stored word at that beat's address during the cycle after edge n, and `dout_drive` is 1.
- R5: For a write beat taken at edge n, `din` and `lane_wr_n` are sampled at the next enabled edge. Lane i (bits 8i+7..8i for 8-bit lanes) is written only when `lane_wr_n[i]` = 0, and the other lanes keep their old contents.
- R6: An advance (`burst_adv` = 1) adds one, modulo 4, to the two low bits of the loaded address and keeps the upper bits and the direction. The fifth beat therefore returns to the start address.
- R7: While `out_en_n` = 1, `dout_drive` is 0 and `dout` is 0, even during a read beat.
- R8: A load while not selected, and any advance after it, gives no drive in the following cycle and writes nothing.
- R9: A read loaded on the edge right after a write load to the same address returns the newly written data. Write and read loads may alternate on every cycle.
- R10: During a write beat, `dout_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address, used on a load |
| rd_wr_n | input | 1 | Direction on a load: 1 read, 0 write |
| burst_adv | input | 1 | 0 load a new address, 1 advance the burst |
| en_n | input | 1 | Active-low clock enable; 1 freezes the block |
| sel0_n | input | 1 | Active-low chip select |
| sel1_n | input | 1 | Active-low chip select |
| sel2 | input | 1 | Active-high chip select |
| lane_wr_n | input | LANES | Active-low per-lane write strobes, one cycle after the write beat |
| out_en_n | input | 1 | Active-low output enable |
| din | input | LANES*LANE_W | Write data, one cycle after the write beat |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_drive | output | 1 | High when the block drives `dout` |

## Verification
Every command lands one register deep. The beat taken at a rising edge has its read data on `dout` from that edge until the next one. Its write data is taken at the next enabled rising edge. The bench drives each cycle's inputs at the falling edge. It then waits one rising edge and compares the outputs at the falling edge after it, so each sample sits in the middle of the data cycle of the beat just taken. A reference memory in the bench, updated at each enabled edge from the requirements, predicts every sample. When `en_n` is high, the bench leaves its reference unchanged and expects the outputs to hold.

// File: rtl/zbt_ft_pkg.sv
package zbt_ft_pkg;

   // Beats per burst and the address bits the burst counter walks.
   localparam int BURST_LEN  = 4;
   localparam int BURST_BITS = $clog2(BURST_LEN);

   // Kind of beat held in the beat register.
   typedef enum logic [1:0] {
      BEAT_IDLE = 2'd0,
      BEAT_RD   = 2'd1,
      BEAT_WR   = 2'd2
   } beat_t;

endpackage

// File: rtl/zbt_ft_burst.sv
// Load/advance sequencing and the beat register.
module zbt_ft_burst
   import zbt_ft_pkg::*;
#(
   parameter int ADDR_W = 6
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_n,
   input  logic              burst_adv,
   input  logic              rd_wr_n,
   input  logic              picked,
   input  logic [ADDR_W-1:0] addr,
   output beat_t             beat_kind,
   output logic [ADDR_W-1:0] beat_addr
);
   localparam int LO = BURST_BITS;

   logic [ADDR_W-1:0] base_q, base_d;
   logic [LO-1:0]     pos_q, pos_d;
   beat_t             kind_d;
   logic [LO-1:0]     low_d;

   always_comb begin
      if (!burst_adv) begin
         kind_d = picked ? (rd_wr_n ? BEAT_RD : BEAT_WR) : BEAT_IDLE;
         base_d = addr;
         pos_d  = '0;
      end else begin
         kind_d = beat_kind;
         base_d = base_q;
         pos_d  = (beat_kind != BEAT_IDLE) ? pos_q + LO'(1) : pos_q;
      end
      low_d = base_d[LO-1:0] + pos_d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat_kind <= BEAT_IDLE;
         base_q    <= '0;
         pos_q     <= '0;
         beat_addr <= '0;
      end else if (!en_n) begin
         beat_kind <= kind_d;
         base_q    <= base_d;
         pos_q     <= pos_d;
         beat_addr <= {base_d[ADDR_W-1:LO], low_d};
      end
   end

endmodule

// File: rtl/zbt_ft_array.sv
// Storage with per-lane write strobes and a combinational read port.
module zbt_ft_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
)(
   input  logic                    clk,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [LANES*LANE_W-1:0] wr_data,
   input  logic [LANES-1:0]        wr_lane_n,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [LANES*LANE_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      logic [LANE_W-1:0] bank [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && !wr_lane_n[ln])
            bank[wr_addr] <= wr_data[ln*LANE_W +: LANE_W];
      end

      assign rd_data[ln*LANE_W +: LANE_W] = bank[rd_addr];
   end

endmodule

// File: rtl/zbt_ft_sram.sv
module zbt_ft_sram
   import zbt_ft_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    rd_wr_n,
   input  logic                    burst_adv,
   input  logic                    en_n,
   input  logic                    sel0_n,
   input  logic                    sel1_n,
   input  logic                    sel2,
   input  logic [LANES-1:0]        lane_wr_n,
   input  logic                    out_en_n,
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES*LANE_W-1:0] dout,
   output logic                    dout_drive
);
   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W <= BURST_BITS) begin : g_bad_addr
      $error("zbt_ft_sram: ADDR_W must exceed the burst counter width");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("zbt_ft_sram: LANES and LANE_W must be positive");
   end

   logic              picked;
   beat_t             beat_kind;
   logic [ADDR_W-1:0] beat_addr;
   logic [DATA_W-1:0] rd_data;
   logic              commit;
   logic              drive;

   assign picked = !sel0_n && !sel1_n && sel2;

   zbt_ft_burst #(.ADDR_W(ADDR_W)) u_burst (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_n      (en_n),
      .burst_adv (burst_adv),
      .rd_wr_n   (rd_wr_n),
      .picked    (picked),
      .addr      (addr),
      .beat_kind (beat_kind),
      .beat_addr (beat_addr)
   );

   // A write beat stores its data at the next enabled edge.
   assign commit = !en_n && rst_n && (beat_kind == BEAT_WR);

   zbt_ft_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk       (clk),
      .wr_en     (commit),
      .wr_addr   (beat_addr),
      .wr_data   (din),
      .wr_lane_n (lane_wr_n),
      .rd_addr   (beat_addr),
      .rd_data   (rd_data)
   );

   assign drive      = (beat_kind == BEAT_RD) && !out_en_n;
   assign dout_drive = drive;
   assign dout       = drive ? rd_data : '0;

endmodule

// File: rtl/zbt_ft_sram_chk.sv
module zbt_ft_sram_chk #(
   parameter int DATA_W = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              rd_wr_n,
   input logic              burst_adv,
   input logic              en_n,
   input logic              sel0_n,
   input logic              sel1_n,
   input logic              sel2,
   input logic              out_en_n,
   input logic [DATA_W-1:0] dout,
   input logic              dout_drive
);
   logic picked;
   assign picked = !sel0_n && !sel1_n && sel2;

   a_r7_oe_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n |-> (!dout_drive && dout == '0));

   a_r8_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_n && !burst_adv && !picked) |=> !dout_drive);

   a_r10_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_n && !burst_adv && picked && !rd_wr_n) |=> !dout_drive);

   a_r4_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_n && !burst_adv && picked && rd_wr_n) |=> (out_en_n || dout_drive));

   a_r6_advance_keeps_read: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_n && burst_adv && dout_drive) |=> (out_en_n || dout_drive));

   a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (en_n && !out_en_n) |=> (out_en_n || ($stable(dout) && $stable(dout_drive))));

endmodule

bind zbt_ft_sram zbt_ft_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_wr_n    (rd_wr_n),
   .burst_adv  (burst_adv),
   .en_n       (en_n),
   .sel0_n     (sel0_n),
   .sel1_n     (sel1_n),
   .sel2       (sel2),
   .out_en_n   (out_en_n),
   .dout       (dout),
   .dout_drive (dout_drive)
);

// File: tb/zbt_ft_sram_test.sv
module zbt_ft_sram_test;
   localparam int AW = 6;
   localparam int NL = 4;
   localparam int LW = 8;
   localparam int DW = NL * LW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          rd_wr_n = 1'b1, burst_adv = 1'b1, en_n = 1'b1;
   logic          sel0_n = 1'b1, sel1_n = 1'b1, sel2 = 1'b0;
   logic [NL-1:0] lane_wr_n = '1;
   logic          out_en_n = 1'b0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_drive;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   // Reference state.
   logic [DW-1:0] mm [DEPTH];
   int            m_run = 0, m_kind = 0; // 0 idle, 1 read, 2 write
   logic [AW-1:0] m_base = '0, m_addr = '0;
   logic [1:0]    m_pos = '0;
   logic [DW-1:0] salt = 32'h0;

   always #2.5 clk = ~clk;

   zbt_ft_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd_wr_n(rd_wr_n),
      .burst_adv(burst_adv), .en_n(en_n), .sel0_n(sel0_n), .sel1_n(sel1_n),
      .sel2(sel2), .lane_wr_n(lane_wr_n), .out_en_n(out_en_n), .din(din),
      .dout(dout), .dout_drive(dout_drive)
   );

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
      return (DW'(a) * 32'h0103_0507) ^ salt;
   endfunction

   task automatic check(input string tag, input logic exp_oe, input logic [DW-1:0] exp_d);
      checks++;
      if (dout_drive !== exp_oe || dout !== exp_d) begin
         errors++;
         $display("FAIL %s: drive=%0b dout=%h expected drive=%0b dout=%h",
                  tag, dout_drive, dout, exp_oe, exp_d);
      end
   endtask

   // One cycle: drive at the falling edge, take the rising edge, check at the next falling edge.
   task automatic step(input string tag, input logic e_n, input logic adv, input logic rw,
                       input logic [AW-1:0] a, input logic s0, input logic s1, input logic s2,
                       input logic oe, input logic [NL-1:0] bw, input logic [DW-1:0] d);
      logic pk;
      logic x_oe;
      en_n = e_n; burst_adv = adv; rd_wr_n = rw; addr = a;
      sel0_n = s0; sel1_n = s1; sel2 = s2; out_en_n = oe; lane_wr_n = bw; din = d;
      @(posedge clk);
      if (!e_n) begin
         if (m_kind == 2)
            for (int i = 0; i < NL; i++)
               if (!bw[i]) mm[m_addr][i*LW +: LW] = d[i*LW +: LW];
         pk = !s0 && !s1 && s2;
         if (!adv) begin
            m_run = pk ? (rw ? 1 : 2) : 0;
            m_base = a;
            m_pos = 2'd0;
         end else if (m_run != 0) begin
            m_pos = m_pos + 2'd1;
         end
         m_kind = m_run;
         m_addr = {m_base[AW-1:2], m_base[1:0] + m_pos};
      end
      @(negedge clk);
      x_oe = (m_kind == 1) && !oe;
      check(tag, x_oe, x_oe ? mm[m_addr] : '0);
   endtask

   // Selected, enabled cycle; write data is the pattern of the beat now in flight.
   task automatic go(input string tag, input logic adv, input logic rw,
                     input logic [AW-1:0] a, input logic [NL-1:0] bw);
      step(tag, 1'b0, adv, rw, a, 1'b0, 1'b0, 1'b1, 1'b0, bw, pat(m_addr));
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) mm[i] = '0;
      @(negedge clk);
      check("R1", 1'b0, '0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: idle after reset, advancing while nothing was loaded
      go("R1", 1'b1, 1'b1, 6'd0, '1);
      go("R1", 1'b1, 1'b1, 6'd0, '1);

      // R5/R6: fill every word with write bursts starting at varied offsets
      salt = 32'h1111_0000;
      for (int b = 0; b < DEPTH / 4; b++)
         for (int j = 0; j < 4; j++)
            go("R6", (j != 0), 1'b0, AW'(b * 4 + (b % 4)), '0);
      go("R5", 1'b0, 1'b1, 6'd0, '0); // last write data lands with this read load

      // R4/R6: read bursts of five beats, the fifth wrapping to the start
      for (int b = 0; b < DEPTH / 4; b++)
         for (int j = 0; j < 5; j++)
            go("R6", (j != 0), 1'b1, AW'(b * 4 + ((b + 1) % 4)), '1);

      // R5: every lane strobe pattern on its own word, then read back
      salt = 32'hA5C3_9600;
      for (int m = 0; m < 16; m++) begin
         go("R10", 1'b0, 1'b0, AW'(16 + m), '1);
         go("R5", 1'b0, 1'b1, AW'(16 + m), NL'(m));
         go("R5", 1'b1, 1'b1, 6'd0, '1);
      end

      // R9: write and read loads alternating every cycle, same and other addresses
      salt = 32'h5A5A_0F0F;
      for (int k = 0; k < 12; k++) begin
         go("R9", 1'b0, 1'b0, AW'(k * 5), '1);
         go("R9", 1'b0, 1'b1, AW'((k % 2) ? k * 5 : k * 3), '0);
      end

      // R2: a write held by stalls takes the data of the enabled edge
      salt = 32'h0BAD_F00D;
      go("R2", 1'b0, 1'b0, 6'd40, '1);
      step("R2", 1'b1, 1'b1, 1'b1, 6'd7, 1'b0, 1'b0, 1'b1, 1'b0, '0, 32'hDEAD_BEEF);
      step("R2", 1'b1, 1'b0, 1'b1, 6'd9, 1'b0, 1'b0, 1'b1, 1'b0, '0, 32'hFEED_0001);
      go("R2", 1'b0, 1'b1, 6'd40, '0);
      // R2: a read burst frozen midway keeps its data
      go("R2", 1'b1, 1'b1, 6'd0, '1);
      for (int s = 0; s < 3; s++)
         step("R2", 1'b1, 1'b0, 1'b0, 6'd3, 1'b0, 1'b0, 1'b1, 1'b0, '0, '0);
      go("R2", 1'b1, 1'b1, 6'd0, '1);

      // R3/R8: write loads with each select inactive in turn write nothing
      salt = 32'h7777_7777;
      step("R8", 1'b0, 1'b0, 1'b0, 6'd50, 1'b1, 1'b0, 1'b1, 1'b0, '1, '0);
      step("R8", 1'b0, 1'b1, 1'b0, 6'd0, 1'b0, 1'b1, 1'b1, 1'b0, '0, 32'h1234_5678);
      step("R3", 1'b0, 1'b0, 1'b0, 6'd51, 1'b0, 1'b1, 1'b1, 1'b0, '1, '0);
      step("R3", 1'b0, 1'b0, 1'b0, 6'd52, 1'b0, 1'b0, 1'b0, 1'b0, '0, 32'h2345_6789);
      step("R8", 1'b0, 1'b1, 1'b1, 6'd0, 1'b1, 1'b1, 1'b0, 1'b0, '0, 32'h3456_789A);
      for (int a = 48; a < 56; a++)
         go("R8", (a % 4 != 0), 1'b1, AW'(a), '1);
      // R3: read load while deselected gives no drive
      step("R3", 1'b0, 1'b0, 1'b1, 6'd50, 1'b0, 1'b0, 1'b0, 1'b0, '1, '0);

      // R7: output enable high during a read burst, then low again
      go("R7", 1'b0, 1'b1, 6'd60, '1);
      step("R7", 1'b0, 1'b1, 1'b1, 6'd0, 1'b0, 1'b0, 1'b1, 1'b1, '1, '0);
      step("R7", 1'b0, 1'b1, 1'b1, 6'd0, 1'b0, 1'b0, 1'b1, 1'b1, '1, '0);
      go("R7", 1'b1, 1'b1, 6'd0, '1);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule